// File: doc/BRIEF.md
# Processor Mode and Exception Controller

This block keeps the current program status word of a 32-bit processor core, together with one saved copy for each exception mode. Each clock it looks at six exception sources. Two are level-sensitive interrupt pins, active low, and each is gated by its own disable bit in the status word. The other four are single-cycle pulses from the core: undefined instruction, software interrupt, prefetch abort and data abort. When a source wins, the block switches the processor into the matching exception mode. It stores the pre-entry status in that mode's saved register, sets the interrupt disable bits, leaves the compressed-instruction state, and presents a vector address with a one-cycle strobe.

Software reaches the status word through a write port with a per-field byte mask. The effect of a write depends on the current privilege level. A return request copies the saved status of the current exception mode back into the live status word. Register banking, the pipeline and instruction decode are handled elsewhere. The block only reports the current mode and status bits so that those parts can act on them.

Top module: `psr_exc_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the mode is supervisor (10011), I=1, F=1, T=0, all flags are zero, `cpsr_o` reads 0x000000D3, `vector_o` is 0 and `exc_taken_o` is 0.
- R2: The layout of `cpsr_o` is as follows: N bit 31, Z bit 30, C bit 29, V bit 28, Q bit 27, I bit 7, F bit 6, T bit 5 and mode bits 4:0. Bits 26:8 always read zero. The mode codes are user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111.
- R3: In user mode, a write with mask bit 3 set loads bits 31:27 of the write data into the flags. Control-field data is ignored.
- R4: In any other mode, mask bit 3 loads the flags and mask bit 0 loads I, F, T and the mode from data bits 7:0. Mask bits 2:1 have no effect. A control write that carries an unlisted mode code leaves the control field unchanged.
- R5: An interrupt is taken only while `irq_n` is 0 and I is 0. A fast interrupt is taken only while `fiq_n` is 0 and F is 0. A pin held low while its disable bit is 1 causes no entry.
- R6: On entry, the mode becomes the target mode, I is set, T is cleared and the flags are kept. F is also set on fast-interrupt entry and is otherwise kept. `exc_taken_o` is 1 for the cycle after the sampling edge. The targets are data abort and prefetch abort to abort, fast interrupt to fast interrupt, interrupt to interrupt, undefined to undefined, and software interrupt to supervisor.
- R7: `vector_o` gives the entry address of the exception last taken. The addresses are undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, interrupt 0x18 and fast interrupt 0x1C.
- R8: Simultaneous sources are resolved highest first: data abort, fast interrupt, interrupt, prefetch abort, undefined, software interrupt. A pulse that loses is dropped.
- R9: On entry, the status as it stood before that edge is copied into the target mode's saved register. A same-cycle write has no effect on this copy.
- R10: In an exception mode, a return request replaces the status with that mode's saved value. In user or system mode, the request is ignored.
- R11: An exception outranks a return and a write in the same cycle. A return outranks a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_n | input | 1 | Interrupt request, active low, level |
| fiq_n | input | 1 | Fast interrupt request, active low, level |
| undef_i | input | 1 | Undefined instruction pulse |
| swi_i | input | 1 | Software interrupt pulse |
| pabt_i | input | 1 | Prefetch abort pulse |
| dabt_i | input | 1 | Data abort pulse |
| psr_wr_i | input | 1 | Status write request |
| psr_wr_mask_i | input | 4 | Field mask: bit 3 flags, bit 0 control |
| psr_wr_data_i | input | 32 | Status write data |
| eret_i | input | 1 | Return-from-exception request |
| mode_o | output | 5 | Current mode code |
| cpsr_o | output | 32 | Current status word |
| vector_o | output | 32 | Vector address of the last exception taken |
| exc_taken_o | output | 1 | One-cycle exception-entry strobe |

## Verification
The bench first drops into user mode with T set. It then checks that a control write there leaves I, F, T and the mode untouched. A design that missed the privilege gate would let user code mask interrupts or leave user mode. Interrupt pins are held low across two cycles and held low while masked. A level-triggered design that ignored the disable bits would re-enter every cycle or enter while masked. Nested entries (abort, then fast interrupt, then two returns) and same-cycle collisions of exceptions, writes and returns show whether the saved copy holds the pre-entry value and whether the priority order is kept. A design that saved the status after the write, or that let a return override an entry, would restore the wrong status on return.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W     = 32;
  localparam int MODE_W    = 5;
  localparam int FLAG_W    = 5;
  localparam int FIELD_N   = PSR_W / 8;
  localparam int NUM_SRC   = 6;
  localparam int NUM_BANKS = 5;

  // source index = priority rank, 0 is highest
  localparam int SRC_DABT = 0;
  localparam int SRC_FIQ  = 1;
  localparam int SRC_IRQ  = 2;
  localparam int SRC_PABT = 3;
  localparam int SRC_UND  = 4;
  localparam int SRC_SWI  = 5;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } mode_e;

  typedef struct packed {
    logic [FLAG_W-1:0] flags;
    logic              irq_dis;
    logic              fiq_dis;
    logic              thumb;
    logic [MODE_W-1:0] mode;
  } psr_t;

  localparam psr_t PSR_RESET = '{flags: '0, irq_dis: 1'b1, fiq_dis: 1'b1,
                                 thumb: 1'b0, mode: MODE_SVC};

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
      MODE_ABT, MODE_UND, MODE_SYS: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  function automatic logic mode_banked(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND: return 1'b1;
      default:                                          return 1'b0;
    endcase
  endfunction

  function automatic int bank_index(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: return 0;
      MODE_IRQ: return 1;
      MODE_SVC: return 2;
      MODE_ABT: return 3;
      MODE_UND: return 4;
      default:  return 0;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] src_mode(input int s);
    case (s)
      SRC_DABT: return MODE_ABT;
      SRC_FIQ:  return MODE_FIQ;
      SRC_IRQ:  return MODE_IRQ;
      SRC_PABT: return MODE_ABT;
      SRC_UND:  return MODE_UND;
      default:  return MODE_SVC;
    endcase
  endfunction

  function automatic logic [7:0] src_vector(input int s);
    case (s)
      SRC_DABT: return 8'h10;
      SRC_FIQ:  return 8'h1C;
      SRC_IRQ:  return 8'h18;
      SRC_PABT: return 8'h0C;
      SRC_UND:  return 8'h04;
      default:  return 8'h08;
    endcase
  endfunction

  function automatic logic [PSR_W-1:0] psr_pack(input psr_t p);
    return {p.flags, {(PSR_W-FLAG_W-3-MODE_W){1'b0}},
            p.irq_dis, p.fiq_dis, p.thumb, p.mode};
  endfunction
endpackage

// File: rtl/psr_rst_sync.sv
module psr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic arst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign arst_n = sync_q[STAGES-1];
endmodule

// File: rtl/psr_exc_arb.sv
module psr_exc_arb
  import psr_pkg::*;
#(
  parameter int VEC_W = 32
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              irq_n,
  input  logic              fiq_n,
  input  logic              irq_dis,
  input  logic              fiq_dis,
  input  logic              dabt,
  input  logic              pabt,
  input  logic              undef,
  input  logic              swi,
  output logic              take,
  output logic [MODE_W-1:0] tgt_mode,
  output logic [VEC_W-1:0]  tgt_vec,
  output logic              tgt_set_f
);
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] grant;
  logic               found;

  always_comb begin
    req           = '0;
    req[SRC_DABT] = dabt;
    req[SRC_FIQ]  = ~fiq_n & ~fiq_dis;
    req[SRC_IRQ]  = ~irq_n & ~irq_dis;
    req[SRC_PABT] = pabt;
    req[SRC_UND]  = undef;
    req[SRC_SWI]  = swi;
  end

  // fixed priority: lowest index wins
  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (req[s] && !found) begin
        grant[s] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    tgt_mode  = '0;
    tgt_vec   = '0;
    tgt_set_f = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (grant[s]) begin
        tgt_mode  = src_mode(s);
        tgt_vec   = VEC_W'(src_vector(s));
        tgt_set_f = (s == SRC_FIQ);
      end
    end
  end

  assign take = |grant;

  assert_target_banked_R6: assert property (@(posedge clk) disable iff (!arst_n)
    take |-> mode_banked(tgt_mode));

  assert_fiq_beats_irq_R8: assert property (@(posedge clk) disable iff (!arst_n)
    (take && tgt_mode == MODE_IRQ) |-> (fiq_n || fiq_dis) && !dabt);
endmodule

// File: rtl/psr_spsr_bank.sv
module psr_spsr_bank
  import psr_pkg::*;
#(
  parameter int NUM = NUM_BANKS,
  localparam int IDX_W = $clog2(NUM)
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  psr_t             wr_val,
  input  logic [IDX_W-1:0] rd_idx,
  output psr_t             rd_val
);
  psr_t bank_q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_bank
    logic we;
    assign we = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)  bank_q[g] <= PSR_RESET;
      else if (we)  bank_q[g] <= wr_val;
    end
  end

  always_comb begin
    rd_val = PSR_RESET;
    for (int g = 0; g < NUM; g++) begin
      if (rd_idx == IDX_W'(g)) rd_val = bank_q[g];
    end
  end

  assert_write_in_range_R9: assert property (@(posedge clk) disable iff (!arst_n)
    wr_en |-> (int'(wr_idx) < NUM));
endmodule

// File: rtl/psr_exc_ctrl.sv
module psr_exc_ctrl
  import psr_pkg::*;
#(
  parameter int VEC_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_n,
  input  logic               fiq_n,
  input  logic               undef_i,
  input  logic               swi_i,
  input  logic               pabt_i,
  input  logic               dabt_i,
  input  logic               psr_wr_i,
  input  logic [FIELD_N-1:0] psr_wr_mask_i,
  input  logic [PSR_W-1:0]   psr_wr_data_i,
  input  logic               eret_i,
  output logic [MODE_W-1:0]  mode_o,
  output logic [PSR_W-1:0]   cpsr_o,
  output logic [VEC_W-1:0]   vector_o,
  output logic               exc_taken_o
);
  localparam int IDX_W    = $clog2(NUM_BANKS);
  localparam int FLAG_LSB = PSR_W - FLAG_W;
  localparam int FLD_FLAG = FIELD_N - 1;
  localparam int FLD_CTRL = 0;

  logic arst_n;

  psr_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .arst_n (arst_n)
  );

  psr_t             psr_q, psr_nx;
  logic [VEC_W-1:0] vec_q, vec_nx;
  logic             taken_q, taken_nx;

  logic              exc_take;
  logic [MODE_W-1:0] exc_mode;
  logic [VEC_W-1:0]  exc_vec;
  logic              exc_set_f;

  psr_exc_arb #(.VEC_W(VEC_W)) u_arb (
    .clk       (clk),
    .arst_n    (arst_n),
    .irq_n     (irq_n),
    .fiq_n     (fiq_n),
    .irq_dis   (psr_q.irq_dis),
    .fiq_dis   (psr_q.fiq_dis),
    .dabt      (dabt_i),
    .pabt      (pabt_i),
    .undef     (undef_i),
    .swi       (swi_i),
    .take      (exc_take),
    .tgt_mode  (exc_mode),
    .tgt_vec   (exc_vec),
    .tgt_set_f (exc_set_f)
  );

  psr_t             spsr_rd;
  logic [IDX_W-1:0] spsr_wr_idx, spsr_rd_idx;

  assign spsr_wr_idx = IDX_W'(bank_index(exc_mode));
  assign spsr_rd_idx = IDX_W'(bank_index(psr_q.mode));

  psr_spsr_bank #(.NUM(NUM_BANKS)) u_bank (
    .clk    (clk),
    .arst_n (arst_n),
    .wr_en  (exc_take),
    .wr_idx (spsr_wr_idx),
    .wr_val (psr_q),
    .rd_idx (spsr_rd_idx),
    .rd_val (spsr_rd)
  );

  logic privileged, may_return, ctrl_ok;
  logic unused_wr_bits;

  assign privileged = (psr_q.mode != MODE_USR);
  assign may_return = mode_banked(psr_q.mode);
  assign ctrl_ok    = privileged && mode_legal(psr_wr_data_i[MODE_W-1:0]);
  assign unused_wr_bits = &{1'b0, psr_wr_data_i[FLAG_LSB-1:8],
                            psr_wr_mask_i[FLD_FLAG-1:FLD_CTRL+1]};

  always_comb begin
    psr_nx   = psr_q;
    vec_nx   = vec_q;
    taken_nx = 1'b0;
    if (exc_take) begin
      psr_nx.mode    = exc_mode;
      psr_nx.irq_dis = 1'b1;
      psr_nx.thumb   = 1'b0;
      if (exc_set_f) psr_nx.fiq_dis = 1'b1;
      vec_nx   = exc_vec;
      taken_nx = 1'b1;
    end else if (eret_i && may_return) begin
      psr_nx = spsr_rd;
    end else if (psr_wr_i) begin
      if (psr_wr_mask_i[FLD_FLAG])
        psr_nx.flags = psr_wr_data_i[PSR_W-1:FLAG_LSB];
      if (psr_wr_mask_i[FLD_CTRL] && ctrl_ok) begin
        psr_nx.irq_dis = psr_wr_data_i[7];
        psr_nx.fiq_dis = psr_wr_data_i[6];
        psr_nx.thumb   = psr_wr_data_i[5];
        psr_nx.mode    = psr_wr_data_i[MODE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      psr_q   <= PSR_RESET;
      vec_q   <= '0;
      taken_q <= 1'b0;
    end else begin
      psr_q   <= psr_nx;
      vec_q   <= vec_nx;
      taken_q <= taken_nx;
    end
  end

  assign mode_o      = psr_q.mode;
  assign cpsr_o      = psr_pack(psr_q);
  assign vector_o    = vec_q;
  assign exc_taken_o = taken_q;

  logic [7:0] ctrl_bits;
  assign ctrl_bits = cpsr_o[7:0];

  assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!arst_n)
    mode_legal(mode_o));

  assert_entry_masks_R6: assert property (@(posedge clk) disable iff (!arst_n)
    exc_taken_o |-> (cpsr_o[7] && !cpsr_o[5]));

  assert_irq_unmasked_R5: assert property (@(posedge clk) disable iff (!arst_n)
    (exc_taken_o && vector_o == VEC_W'(8'h18)) |-> !$past(cpsr_o[7]));

  assert_saved_copy_R9: assert property (@(posedge clk) disable iff (!arst_n)
    exc_taken_o |-> (spsr_rd == $past(psr_q)));

  assert_user_ctrl_locked_R3: assert property (@(posedge clk) disable iff (!arst_n)
    (psr_wr_i && mode_o == MODE_USR && !exc_take) |=> $stable(ctrl_bits));

  assert_return_ignored_R10: assert property (@(posedge clk) disable iff (!arst_n)
    (eret_i && !psr_wr_i && !exc_take &&
     (mode_o == MODE_USR || mode_o == MODE_SYS)) |=> $stable(cpsr_o));
endmodule

// File: tb/sim_psr_exc_ctrl.sv
`timescale 1ns/1ps
module sim_psr_exc_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_n, fiq_n, undef_i, swi_i, pabt_i, dabt_i;
  logic        psr_wr_i, eret_i;
  logic [3:0]  psr_wr_mask_i;
  logic [31:0] psr_wr_data_i;
  logic [4:0]  mode_o;
  logic [31:0] cpsr_o, vector_o;
  logic        exc_taken_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  psr_exc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .fiq_n(fiq_n),
    .undef_i(undef_i), .swi_i(swi_i), .pabt_i(pabt_i), .dabt_i(dabt_i),
    .psr_wr_i(psr_wr_i), .psr_wr_mask_i(psr_wr_mask_i),
    .psr_wr_data_i(psr_wr_data_i), .eret_i(eret_i),
    .mode_o(mode_o), .cpsr_o(cpsr_o), .vector_o(vector_o),
    .exc_taken_o(exc_taken_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // called just after a falling edge; applies one cycle of stimulus
  task automatic step(input logic und, input logic sw, input logic pa, input logic da,
                      input logic irqn, input logic fiqn, input logic wr,
                      input logic [3:0] m, input logic [31:0] d, input logic ret);
    undef_i = und; swi_i = sw; pabt_i = pa; dabt_i = da;
    irq_n = irqn; fiq_n = fiqn;
    psr_wr_i = wr; psr_wr_mask_i = m; psr_wr_data_i = d; eret_i = ret;
    @(negedge clk);
    undef_i = 0; swi_i = 0; pabt_i = 0; dabt_i = 0;
    psr_wr_i = 0; psr_wr_mask_i = 0; psr_wr_data_i = 0; eret_i = 0;
  endtask

  task automatic do_write(input logic [3:0] m, input logic [31:0] d);
    step(0, 0, 0, 0, 1, 1, 1, m, d, 0);
  endtask

  task automatic do_return();
    step(0, 0, 0, 0, 1, 1, 0, 4'h0, 32'h0, 1);
  endtask

  task automatic t_reset();
    chk("R1 cpsr in reset", cpsr_o, 32'h0000_00D3);
    chk("R1 taken in reset", {31'b0, exc_taken_o}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 cpsr after release", cpsr_o, 32'h0000_00D3);
    chk("R1 mode after release", {27'b0, mode_o}, 32'h13);
    chk("R1 vector after release", vector_o, 32'h0);
  endtask

  task automatic t_priv_write();
    do_write(4'b1111, 32'hFFFF_FF1F);
    chk("R4 R2 full write, reserved zero", cpsr_o, 32'hF800_001F);
    do_write(4'b0001, 32'hFFFF_FF15);
    chk("R4 illegal mode code ignored", cpsr_o, 32'hF800_001F);
    do_write(4'b0110, 32'h0000_0000);
    chk("R4 reserved mask bits no effect", cpsr_o, 32'hF800_001F);
    do_return();
    chk("R10 return in system ignored", cpsr_o, 32'hF800_001F);
    do_write(4'b0001, 32'h0000_0030);
    chk("R4 enter user with T set", cpsr_o, 32'hF800_0030);
  endtask

  task automatic t_user_write();
    do_write(4'b1001, 32'h5000_00D3);
    chk("R3 user flags only", cpsr_o, 32'h5000_0030);
    do_return();
    chk("R10 return in user ignored", cpsr_o, 32'h5000_0030);
  endtask

  task automatic t_irq();
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R6 irq entry status", cpsr_o, 32'h5000_0092);
    chk("R6 irq strobe", {31'b0, exc_taken_o}, 32'h1);
    chk("R7 irq vector", vector_o, 32'h18);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R5 held irq masked no reentry", {31'b0, exc_taken_o}, 32'h0);
    chk("R5 held irq status stable", cpsr_o, 32'h5000_0092);
    do_return();
    chk("R10 R9 return from irq", cpsr_o, 32'h5000_0030);
  endtask

  task automatic t_fiq();
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R6 fiq entry sets F", cpsr_o, 32'h5000_00D1);
    chk("R7 fiq vector", vector_o, 32'h1C);
    do_return();
    chk("R10 return from fiq", cpsr_o, 32'h5000_0030);
  endtask

  task automatic t_priority_nested();
    step(1, 1, 1, 1, 0, 0, 0, 0, 0, 0);
    chk("R8 data abort wins all", cpsr_o, 32'h5000_0097);
    chk("R7 data abort vector", vector_o, 32'h10);
    step(0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
    chk("R8 losing pulses dropped", {31'b0, exc_taken_o}, 32'h0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R6 fiq nested in abort", cpsr_o, 32'h5000_00D1);
    do_return();
    chk("R9 return to abort", cpsr_o, 32'h5000_0097);
    do_return();
    chk("R9 return to user", cpsr_o, 32'h5000_0030);
  endtask

  task automatic t_pairs();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 fiq over irq", vector_o, 32'h1C);
    do_return();
    chk("R10 back from fiq pair", cpsr_o, 32'h5000_0030);
    step(1, 0, 1, 0, 1, 1, 0, 0, 0, 0);
    chk("R8 prefetch abort over undefined", cpsr_o, 32'h5000_0097);
    chk("R7 prefetch abort vector", vector_o, 32'h0C);
    do_return();
    step(1, 1, 0, 0, 1, 1, 0, 0, 0, 0);
    chk("R8 undefined over swi", cpsr_o, 32'h5000_009B);
    chk("R7 undefined vector", vector_o, 32'h04);
    do_return();
    step(0, 1, 0, 0, 1, 1, 0, 0, 0, 0);
    chk("R6 swi to supervisor", cpsr_o, 32'h5000_0093);
    chk("R7 swi vector", vector_o, 32'h08);
  endtask

  task automatic t_collisions();
    step(1, 0, 0, 0, 1, 1, 1, 4'b1111, 32'h0000_001F, 0);
    chk("R11 exception beats write", cpsr_o, 32'h5000_009B);
    do_return();
    chk("R11 R9 saved copy pre-write", cpsr_o, 32'h5000_0093);
    step(0, 0, 0, 0, 1, 1, 1, 4'b1111, 32'h0000_001F, 1);
    chk("R11 return beats write", cpsr_o, 32'h5000_0030);
  endtask

  task automatic t_fiq_masked();
    step(0, 1, 0, 0, 1, 1, 0, 0, 0, 0);
    do_write(4'b0001, 32'h0000_0050);
    chk("R4 user with F set", cpsr_o, 32'h5000_0050);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R5 masked fiq no strobe", {31'b0, exc_taken_o}, 32'h0);
    chk("R5 masked fiq status", cpsr_o, 32'h5000_0050);
  endtask

  task automatic t_reset_again();
    rst_n = 1'b0;
    #1;
    chk("R1 async reset status", cpsr_o, 32'h0000_00D3);
    chk("R1 async reset vector", vector_o, 32'h0);
  endtask

  initial begin
    rst_n = 0; irq_n = 1; fiq_n = 1;
    undef_i = 0; swi_i = 0; pabt_i = 0; dabt_i = 0;
    psr_wr_i = 0; psr_wr_mask_i = 0; psr_wr_data_i = 0; eret_i = 0;
    repeat (3) @(negedge clk);
    t_reset();
    t_priv_write();
    t_user_write();
    t_irq();
    t_fiq();
    t_priority_nested();
    t_pairs();
    t_collisions();
    t_fiq_masked();
    t_reset_again();
    summary();
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end
endmodule